// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the bus-facing controller of a 4096-byte serial memory that sits on a two-wire bus as a slave. It runs on a fast system clock and samples the bus clock and data lines through synchroniser flops. From these samples it finds start and stop conditions, decodes the slave address byte and assembles a 12-bit memory address. It drives the data line only through an open-drain enable: a 1 on that enable pulls the line low.

The block handles writes of one byte or of a whole page. Incoming bytes collect in a page buffer. A self-timed internal write cycle moves them into the storage array, and that cycle begins only when the master sends a stop condition. While the cycle runs, the block stays silent on the bus, so a master can poll with address bytes until it gets an acknowledge. Reads can use the internal address counter (current-address read), or the master can load a new address first with a dummy write (random read). A read continues for as long as the master acknowledges each byte. The storage array is modelled as a register array.

Top module: `twi_eeprom_slave`

## Requirements
- R1: A start condition is SDA falling while SCL is high, and a stop condition is SDA rising while SCL is high. A start seen at any point, including in the middle of a byte, drops the current transfer and returns the block to slave address reception.
- R2: The slave byte carries three select bits in its three most significant positions, bit 7 first. Bits 7 and 5 must equal the inverse of `sel_i[2]` and `sel_i[0]`, and bit 6 must equal `sel_i[1]`. The block acknowledges only on a match. On a mismatch it stays off the bus until the next start.
- R3: Bits 4..1 of the slave byte are address bits 11..8, and bit 0 selects the direction (1 = read, 0 = write).
- R4: In a write, the byte after the slave byte is address bits 7..0. The block acknowledges the slave byte, the word address and every data byte by pulling SDA low during the ninth clock. A byte written to the 12-bit address reads back unchanged after the write cycle.
- R5: In a page write, each data byte advances only the low `PAGE_W` address bits (5 by default, which gives a 32-byte page), so the address wraps inside the page. The upper bits stay fixed, and bytes beyond the page size overwrite earlier ones.
- R6: The internal write cycle starts only at a stop that follows at least one acknowledged data byte, and it lasts `WR_CYCLES` system clocks. During the cycle the block does not acknowledge its slave address. A transfer cut short by a start, with no stop, writes nothing.
- R7: A read sends eight bits, most significant bit first, each one valid while SCL is high, and then releases SDA. If the master acknowledges, the next byte follows. If it does not, the block stops driving SDA until the next start.
- R8: Sequential reads advance all 12 address bits, so the address after 0xFFF is 0x000.
- R9: A random read is a write-direction slave byte and a word address, followed by a repeated start and a read-direction slave byte. It returns the byte at the address just loaded.
- R10: A current-address read uses the internal counter. That counter holds the last address read plus one, or, after a write, the exact address that was last written.
- R11: A stop during or after a read returns the block to idle without starting a write cycle, so the next slave byte is acknowledged at once.
- R12: The SDA enable changes only while SCL is low.
- R13: After reset the SDA enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as sampled |
| sda_i | input | 1 | Bus data line as sampled (wired level) |
| sel_i | input | 3 | Device select pins |
| sda_oe_o | output | 1 | 1 pulls the data line low |

## Verification
The assertions rely on a master that follows the bus rules. It changes SDA only while SCL is low, except when it makes a start or a stop. Each level it sets on SCL or SDA lasts well beyond the synchroniser depth, and it never tries to make a start or a stop while the slave holds SDA low. The bench's master tasks hold every level for at least two system clocks after each SCL edge, and ten clocks for each phase of a bit. They release SDA for every slave-driven bit, and they make starts and stops only after a byte has been acknowledged and the line released. The relation between the enable and SCL is also watched from the bench. The bench tracks expected memory contents only for addresses it has written itself.

// File: rtl/twi_pkg.sv
package twi_pkg;
   localparam int ADDR_W = 12;
   localparam int HI_W   = 4;
   localparam int DATA_W = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WADDR,
      ST_WAACK,
      ST_WDATA,
      ST_DACK,
      ST_RDATA,
      ST_RACK
   } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   if (STAGES < 2) begin : g_bad_stages
      $error("twi_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_p, sda_p;
   logic              scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= '1;
         sda_p <= '1;
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_p <= {scl_p[STAGES-2:0], scl_i};
         sda_p <= {sda_p[STAGES-2:0], sda_i};
         scl_d <= scl_p[STAGES-1];
         sda_d <= sda_p[STAGES-1];
      end
   end

   assign scl_s     = scl_p[STAGES-1];
   assign sda_s     = sda_p[STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
   parameter int AW = 12,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [AW-1:0] raddr_i,
   output logic [DW-1:0] rdata_o
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) mem_q[waddr_i] <= wdata_i;
   end

   assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/twi_write_engine.sv
module twi_write_engine #(
   parameter int AW        = 12,
   parameter int DW        = 8,
   parameter int PAGE_W    = 5,
   parameter int WR_CYCLES = 2000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          wr_en_i,
   input  logic [AW-1:0] wr_addr_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic          go_i,
   output logic          busy_o,
   output logic          pending_o,
   output logic          mem_we_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [DW-1:0] mem_data_o
);
   localparam int PAGE_BYTES = 1 << PAGE_W;
   localparam int TMR_W      = $clog2(WR_CYCLES + 1);
   localparam int BASE_W     = AW - PAGE_W;

   if (WR_CYCLES <= PAGE_BYTES) begin : g_bad_cycles
      $error("twi_write_engine: WR_CYCLES must exceed the page size");
   end

   logic [DW-1:0]         buf_q [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] valid_q;
   logic [BASE_W-1:0]     base_q;
   logic [TMR_W-1:0]      tmr_q;
   logic                  busy_q;
   logic [PAGE_W-1:0]     cidx;

   assign cidx = tmr_q[PAGE_W-1:0];

   always_ff @(posedge clk) begin
      if (wr_en_i && !busy_q) buf_q[wr_addr_i[PAGE_W-1:0]] <= wr_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         base_q  <= '0;
         tmr_q   <= '0;
         busy_q  <= 1'b0;
      end else if (busy_q) begin
         if (tmr_q == TMR_W'(WR_CYCLES - 1)) begin
            busy_q  <= 1'b0;
            valid_q <= '0;
            tmr_q   <= '0;
         end else begin
            tmr_q <= tmr_q + TMR_W'(1);
         end
      end else if (go_i) begin
         busy_q <= 1'b1;
         tmr_q  <= '0;
      end else if (clr_i) begin
         valid_q <= '0;
      end else if (wr_en_i) begin
         valid_q[wr_addr_i[PAGE_W-1:0]] <= 1'b1;
         base_q <= wr_addr_i[AW-1:PAGE_W];
      end
   end

   assign busy_o     = busy_q;
   assign pending_o  = |valid_q;
   assign mem_we_o   = busy_q && (tmr_q < TMR_W'(PAGE_BYTES)) && valid_q[cidx];
   assign mem_addr_o = {base_q, cidx};
   assign mem_data_o = buf_q[cidx];
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
   import twi_pkg::*;
#(
   parameter int         PAGE_W      = 5,
   parameter int         WR_CYCLES   = 2000,
   parameter int         SYNC_STAGES = 2,
   parameter logic [2:0] SEL_INV     = 3'b101
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [2:0] sel_i,
   output logic       sda_oe_o
);
   if (PAGE_W < 1 || PAGE_W > 8) begin : g_bad_page
      $error("twi_eeprom_slave: PAGE_W must be 1..8");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   twi_state_e         st_q;
   logic [3:0]         cnt_q;
   logic [DATA_W-1:0]  sh_q, tx_q;
   logic [HI_W-1:0]    hi_q;
   logic [ADDR_W-1:0]  ptr_q, wp_q;
   logic               oe_q, mack_q, rw_q;
   logic [2:0]         sel_ok;
   logic               sel_match, byte_done, wr_en, go, wr_busy, pending;
   logic               mem_we;
   logic [ADDR_W-1:0]  mem_waddr;
   logic [DATA_W-1:0]  mem_wdata, mem_rdata;
   logic [ADDR_W-1:0]  word_addr;
   logic [PAGE_W-1:0]  wp_lo_nxt;

   for (genvar i = 0; i < 3; i++) begin : g_sel
      assign sel_ok[i] = (sh_q[5+i] == (sel_i[i] ^ SEL_INV[i]));
   end
   assign sel_match = &sel_ok;

   assign byte_done = scl_fall && (cnt_q == 4'd8) && !start_det && !stop_det;
   assign wr_en     = byte_done && (st_q == ST_WDATA);
   assign go        = stop_det && (st_q == ST_WDATA || st_q == ST_DACK) && pending;
   assign word_addr = {hi_q, sh_q};
   assign wp_lo_nxt = wp_q[PAGE_W-1:0] + PAGE_W'(1);

   twi_write_engine #(
      .AW(ADDR_W), .DW(DATA_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)
   ) u_wr (
      .clk(clk), .rst_n(rst_n), .clr_i(start_det), .wr_en_i(wr_en),
      .wr_addr_i(wp_q), .wr_data_i(sh_q), .go_i(go), .busy_o(wr_busy),
      .pending_o(pending), .mem_we_o(mem_we), .mem_addr_o(mem_waddr),
      .mem_data_o(mem_wdata)
   );

   twi_mem_array #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
      .clk(clk), .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(mem_wdata),
      .raddr_i(ptr_q), .rdata_o(mem_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         sh_q   <= '0;
         tx_q   <= '0;
         hi_q   <= '0;
         ptr_q  <= '0;
         wp_q   <= '0;
         oe_q   <= 1'b0;
         mack_q <= 1'b0;
         rw_q   <= 1'b0;
      end else if (start_det) begin
         st_q  <= ST_ADDR;
         cnt_q <= '0;
         oe_q  <= 1'b0;
      end else if (stop_det) begin
         st_q <= ST_IDLE;
         oe_q <= 1'b0;
      end else begin
         case (st_q)
            ST_ADDR, ST_WADDR, ST_WDATA: begin
               if (scl_rise && cnt_q != 4'd8) begin
                  sh_q  <= {sh_q[DATA_W-2:0], sda_s};
                  cnt_q <= cnt_q + 4'd1;
               end else if (byte_done) begin
                  cnt_q <= '0;
                  if (st_q == ST_ADDR) begin
                     if (sel_match && !wr_busy) begin
                        oe_q <= 1'b1;
                        rw_q <= sh_q[0];
                        hi_q <= sh_q[4:1];
                        st_q <= ST_AACK;
                     end else begin
                        st_q <= ST_IDLE;
                     end
                  end else if (st_q == ST_WADDR) begin
                     oe_q  <= 1'b1;
                     ptr_q <= word_addr;
                     wp_q  <= word_addr;
                     st_q  <= ST_WAACK;
                  end else begin
                     oe_q  <= 1'b1;
                     ptr_q <= wp_q;
                     wp_q  <= {wp_q[ADDR_W-1:PAGE_W], wp_lo_nxt};
                     st_q  <= ST_DACK;
                  end
               end
            end
            ST_AACK, ST_WAACK, ST_DACK: begin
               if (scl_fall) begin
                  if (st_q == ST_AACK && rw_q) begin
                     tx_q  <= mem_rdata;
                     oe_q  <= ~mem_rdata[DATA_W-1];
                     ptr_q <= ptr_q + ADDR_W'(1);
                     st_q  <= ST_RDATA;
                  end else begin
                     oe_q <= 1'b0;
                     st_q <= (st_q == ST_AACK) ? ST_WADDR : ST_WDATA;
                  end
               end
            end
            ST_RDATA: begin
               if (scl_rise) begin
                  cnt_q <= cnt_q + 4'd1;
               end else if (scl_fall) begin
                  if (cnt_q == 4'd8) begin
                     oe_q <= 1'b0;
                     st_q <= ST_RACK;
                  end else begin
                     tx_q <= {tx_q[DATA_W-2:0], 1'b0};
                     oe_q <= ~tx_q[DATA_W-2];
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) begin
                  mack_q <= ~sda_s;
               end else if (scl_fall) begin
                  cnt_q <= '0;
                  if (mack_q) begin
                     tx_q  <= mem_rdata;
                     oe_q  <= ~mem_rdata[DATA_W-1];
                     ptr_q <= ptr_q + ADDR_W'(1);
                     st_q  <= ST_RDATA;
                  end else begin
                     st_q <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_oe_o = oe_q;
endmodule

// File: rtl/twi_eeprom_checker.sv
module twi_eeprom_checker
   import twi_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       scl_s,
   input logic       start_det,
   input logic       stop_det,
   input logic       busy,
   input logic       mem_we,
   input logic       sda_oe,
   input twi_state_e st
);
   p_start_restarts_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (st == ST_ADDR));

   p_silent_while_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sda_oe);

   p_cycle_from_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_det));

   p_store_in_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);

   p_idle_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_oe);

   p_oe_moves_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);
endmodule

bind twi_eeprom_slave twi_eeprom_checker u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
   .stop_det(stop_det), .busy(wr_busy), .mem_we(mem_we),
   .sda_oe(sda_oe_o), .st(st_q)
);

// File: tb/twi_eeprom_slave_test.sv
module twi_eeprom_slave_test;
   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [2:0] sel = 3'b010;
   logic       sda_oe;
   logic       sda_w;
   int         n_chk = 0;
   int         n_fail = 0;
   int         oe_hi_moves = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   assign sda_w = sda_m & ~sda_oe;

   twi_eeprom_slave #(.WR_CYCLES(600)) uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_w),
      .sel_i(sel), .sda_oe_o(sda_oe)
   );

   // R12 watch: enable must not move while the bus clock is high
   logic oe_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n && scl_m && (sda_oe !== oe_prev)) oe_hi_moves++;
      oe_prev <= sda_oe;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] sbyte(input logic [3:0] hi, input logic rd);
      return {~sel[2], sel[1], ~sel[0], hi, rd};
   endfunction

   task automatic bus_start();
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0; tick(2);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q/2);
      ack = (sda_w == 1'b0);
      tick(Q/2); scl_m = 1'b0; tick(2);
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] d);
      sda_m = 1'b1;
      d = '0;
      for (int i = 0; i < 8; i++) begin
         tick(Q); scl_m = 1'b1; tick(Q/2);
         d = {d[6:0], sda_w};
         tick(Q/2); scl_m = 1'b0; tick(2);
      end
      sda_m = mack ? 1'b0 : 1'b1;
      tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0; tick(2);
      sda_m = 1'b1;
   endtask

   task automatic poll_ready(output int n);
      logic a;
      n = 0;
      do begin
         n++;
         bus_start();
         send_byte(sbyte(4'h0, 1'b0), a);
         bus_stop();
      end while (!a && n < 20);
   endtask

   // write `cnt` bytes from `d` starting at address `a`, then stop and poll
   task automatic mem_write(input logic [11:0] a, input logic [7:0] d [5],
                            input int cnt, input string tag, output int polls);
      logic ack;
      bus_start();
      send_byte(sbyte(a[11:8], 1'b0), ack); chk({tag, " slave ack"}, ack, 1);
      send_byte(a[7:0], ack);               chk({tag, " word ack"}, ack, 1);
      for (int i = 0; i < cnt; i++) begin
         send_byte(d[i], ack);              chk({tag, " data ack"}, ack, 1);
      end
      bus_stop();
      poll_ready(polls);
   endtask

   // open a read: random when rnd is set (dummy write first)
   task automatic read_open(input logic rnd, input logic [11:0] a, input string tag);
      logic ack;
      bus_start();
      if (rnd) begin
         send_byte(sbyte(a[11:8], 1'b0), ack); chk({tag, " dummy slave ack"}, ack, 1);
         send_byte(a[7:0], ack);               chk({tag, " dummy word ack"}, ack, 1);
         bus_start();
      end
      send_byte(sbyte(a[11:8], 1'b1), ack);    chk({tag, " read slave ack"}, ack, 1);
   endtask

   task automatic t_reset();
      chk("R13 enable after reset", sda_oe, 0);
   endtask

   task automatic t_select();
      logic ack;
      bus_start();
      send_byte({sel, 4'h0, 1'b0}, ack);
      chk("R2 uninverted select refused", ack, 0);
      bus_stop();
      sel = 3'b101; tick(4);
      bus_start();
      send_byte(sbyte(4'h0, 1'b0), ack);
      chk("R2 R3 matching select with pins 101", ack, 1);
      bus_stop();
      sel = 3'b010; tick(4);
   endtask

   task automatic t_byte_write();
      logic [7:0] d [5];
      logic [7:0] r;
      int         polls;
      d = '{8'h5A, 8'h00, 8'h00, 8'h00, 8'h00};
      mem_write(12'h3A7, d, 1, "R4", polls);
      chk("R6 first poll refused during cycle", int'(polls >= 2), 1);
      chk("R6 cycle ends within polls", int'(polls <= 8), 1);
      d[0] = 8'h6B;
      mem_write(12'h3A8, d, 1, "R4", polls);
      read_open(1'b1, 12'h3A7, "R9");
      recv_byte(1'b0, r); bus_stop();
      chk("R9 R4 random read 3A7", r, 8'h5A);
      read_open(1'b0, 12'h000, "R10");
      recv_byte(1'b0, r); bus_stop();
      chk("R10 current read after read gives next", r, 8'h6B);
      d[0] = 8'hC3;
      mem_write(12'h124, d, 1, "R4", polls);
      read_open(1'b0, 12'h000, "R10");
      recv_byte(1'b0, r); bus_stop();
      chk("R10 current read after write gives same", r, 8'hC3);
   endtask

   task automatic t_page_wrap();
      logic [7:0] d [5];
      logic [7:0] r;
      int         polls;
      d = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
      mem_write(12'h21E, d, 5, "R5", polls);
      read_open(1'b1, 12'h21E, "R5");
      recv_byte(1'b1, r); chk("R5 page byte 21E", r, 8'h11);
      recv_byte(1'b0, r); chk("R5 page byte 21F", r, 8'h22);
      bus_stop();
      read_open(1'b1, 12'h200, "R5");
      recv_byte(1'b1, r); chk("R5 wrapped byte 200", r, 8'h33);
      recv_byte(1'b1, r); chk("R5 wrapped byte 201", r, 8'h44);
      recv_byte(1'b0, r); chk("R5 wrapped byte 202", r, 8'h55);
      bus_stop();
   endtask

   task automatic t_seq_wrap();
      logic [7:0] d [5];
      logic [7:0] r;
      int         polls;
      d = '{8'hEE, 8'h00, 8'h00, 8'h00, 8'h00};
      mem_write(12'hFFF, d, 1, "R8", polls);
      d = '{8'h01, 8'h00, 8'h00, 8'h00, 8'h00};
      mem_write(12'h000, d, 2, "R8", polls);
      read_open(1'b1, 12'hFFF, "R8");
      recv_byte(1'b1, r); chk("R8 byte at FFF", r, 8'hEE);
      recv_byte(1'b0, r); chk("R8 R7 rolled to 000", r, 8'h01);
      // no acknowledge given: further clocks must see a released line
      recv_byte(1'b0, r); chk("R7 no data after missing ack", r, 8'hFF);
      bus_stop();
      poll_ready(polls);
      chk("R11 stop after read starts no cycle", polls, 1);
   endtask

   task automatic t_abort();
      logic       ack;
      logic [7:0] r;
      // start inside a byte drops it (R1)
      bus_start();
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
      bus_start();
      send_byte(sbyte(4'h1, 1'b0), ack); chk("R1 address after mid-byte start", ack, 1);
      send_byte(8'h24, ack);             chk("R1 word ack", ack, 1);
      send_byte(8'h99, ack);             chk("R6 data ack before abort", ack, 1);
      // repeated start instead of stop: nothing may be committed (R6)
      bus_start();
      send_byte(sbyte(4'h1, 1'b0), ack); chk("R6 no cycle without stop", ack, 1);
      send_byte(8'h24, ack);
      bus_start();
      send_byte(sbyte(4'h1, 1'b1), ack); chk("R9 read slave ack", ack, 1);
      recv_byte(1'b0, r); bus_stop();
      chk("R6 aborted write left 124 intact", r, 8'hC3);
   endtask

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(5);
      t_reset();
      t_select();
      t_byte_write();
      t_page_wrap();
      t_seq_wrap();
      t_abort();
      chk("R12 enable moved with SCL high", oe_hi_moves, 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule